// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides, for a serial NOR flash device, whether each decoded instruction is honoured. Instruction strobes arrive already decoded, one per cycle. For each strobe the block answers with a one-cycle accept or reject pulse. It also keeps the write-enable latch, the deep power-down state and the seven protection bits. An accepted program, erase or status write also raises a start pulse for the rest of the device.

Writes are gated by several conditions that act together. A power-up lockout counter must expire first. The write-enable latch must be set, and it clears itself when the operation-complete pulse arrives. Deep power-down silences every instruction except the release. The status-register protect bits, combined with the active-low hardware protect pin, decide whether the protection settings may change. The block-protect bits select a region at the top or bottom of the array, and any program or erase that touches that region is refused.

Top module: `flashProtectGate`

## Requirements
- R1: While `pwrGood` is low, `wel` and `powerDown` are 0, the lockout counter restarts, and no strobe produces any pulse. The protection bits are cleared only by `rstN`.
- R2: After `pwrGood` rises, `writeLock` stays high until `LOCKOUT_CYCLES` cycles have passed with power good. While `writeLock` is high, write enable, program, all erases and status write are rejected.
- R3: `wel` is 0 after reset or power loss. An accepted write enable sets it. An accepted write disable clears it.
- R4: Program, erase and status write are rejected while `wel` is 0, and a rejection for this reason leaves `wel` unchanged.
- R5: An `opDone` pulse clears `wel`.
- R6: An accepted power-down sets `powerDown`. While `powerDown` is set, every strobe other than release is rejected and changes no state. An accepted release clears `powerDown`.
- R7: An accepted status write loads `srIn` into `srBits`. The bit order is {srp1, srp0, sec, tb, bp[2:0]}, with bp in bits 2..0.
- R8: A status write needs srp1=0 and either srp0=0 or `wpN`=1. Otherwise it is rejected and `wel` and `srBits` keep their values.
- R9: Protected length: 0 if bp=0; the whole array if bp=7; with sec=1, 4 KiB shifted left by min(bp,4)-1; with sec=0, 64 KiB shifted left by bp-1. tb=1 places the region at address 0, and tb=0 places it at the top of the array. Program checks one address, sector erase checks its aligned 4 KiB, and block erase checks its aligned 64 KiB. A request that overlaps the region is rejected and clears `wel`.
- R10: Each strobe seen with power good gives exactly one of `acceptPulse` or `rejectPulse`, one cycle later, lasting one cycle. `opStart` accompanies each accepted program, erase or status write.
- R11: Chip erase is rejected whenever bp is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supply above reset threshold |
| wpN | input | 1 | Hardware write-protect pin, active low |
| opDone | input | 1 | Program/erase/status write complete pulse |
| cmdWren | input | 1 | Write enable strobe |
| cmdWrdi | input | 1 | Write disable strobe |
| cmdProg | input | 1 | Page program strobe |
| cmdSectErase | input | 1 | 4 KiB sector erase strobe |
| cmdBlkErase | input | 1 | 64 KiB block erase strobe |
| cmdChipErase | input | 1 | Chip erase strobe |
| cmdWrsr | input | 1 | Status write strobe |
| cmdPdown | input | 1 | Power-down strobe |
| cmdRelPd | input | 1 | Release power-down strobe |
| targetAddr | input | ADDR_W | Byte address of program/erase |
| srIn | input | 7 | New protection bits for status write |
| acceptPulse | output | 1 | Instruction accepted |
| rejectPulse | output | 1 | Instruction rejected |
| opStart | output | 1 | Program/erase/status write starts |
| wel | output | 1 | Write-enable latch |
| powerDown | output | 1 | Deep power-down state |
| writeLock | output | 1 | Power-up lockout still running |
| srBits | output | 7 | Protection bits {srp1,srp0,sec,tb,bp[2:0]} |

## Verification
Every result is registered exactly once. A strobe presented before clock edge n produces its pulses, and its new `wel`, `powerDown` and `srBits` values, right after edge n. The driver stamps each expected item with the cycle in which it falls due. The monitor compares that item at the falling edge of that cycle only, so no comparison can land one cycle early or late. The lockout boundary is checked in the same way: a strobe sampled when the counter reads `LOCKOUT_CYCLES`-1 is rejected, and one sampled a cycle later is accepted.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setPd;
    logic clrPd;
    logic loadSr;
  } regStrobe_t;

  typedef struct packed {
    logic       srp1;
    logic       srp0;
    logic       sec;
    logic       tb;
    logic [2:0] bp;
  } protBits_t;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } opKind_t;

endpackage

// File: rtl/fpgRegion.sv
module fpgRegion
  import fpg_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int SECTOR_AW = 12,
  parameter int BLOCK_AW  = 16
) (
  input  protBits_t           prot,
  input  opKind_t             kind,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit
);

  localparam int LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0]  MEM_BYTES = LEN_W'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECTOR_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((64'd1 << BLOCK_AW) - 64'd1);

  logic [2:0]        bpCap;
  logic [LEN_W-1:0]  protLen;
  logic [LEN_W-1:0]  topStart;
  logic [ADDR_W-1:0] lo;
  logic [ADDR_W-1:0] hi;

  always_comb begin
    bpCap = (prot.bp > 3'd4) ? 3'd4 : prot.bp;
    if (prot.bp == 3'd0)
      protLen = '0;
    else if (prot.bp == 3'd7)
      protLen = MEM_BYTES;
    else if (prot.sec)
      protLen = LEN_W'(1) << (SECTOR_AW + int'(bpCap) - 1);
    else
      protLen = LEN_W'(1) << (BLOCK_AW + int'(prot.bp) - 1);
  end

  always_comb begin
    unique case (kind)
      OP_PROG: begin lo = addr;               hi = addr;           end
      OP_SECT: begin lo = addr & ~SECT_MASK;  hi = lo | SECT_MASK; end
      OP_BLK:  begin lo = addr & ~BLK_MASK;   hi = lo | BLK_MASK;  end
      default: begin lo = '0;                 hi = '1;             end
    endcase
  end

  assign topStart = MEM_BYTES - protLen;
  assign hit = (protLen != '0) &&
               (prot.tb ? ({1'b0, lo} < protLen) : ({1'b0, hi} >= topStart));

endmodule

// File: rtl/fpgRegs.sv
module fpgRegs
  import fpg_pkg::*;
#(
  parameter int LOCKOUT_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  regStrobe_t strobe,
  input  protBits_t  srNext,
  output logic       wel,
  output logic       powerDown,
  output protBits_t  status,
  output logic       lockoutDone
);

  localparam int CNT_W = $clog2(LOCKOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LOCKOUT_CYCLES);

  logic [CNT_W-1:0] lockCnt;

  assign lockoutDone = (lockCnt == CNT_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt   <= '0;
      wel       <= 1'b0;
      powerDown <= 1'b0;
    end else if (!pwrGood) begin
      lockCnt   <= '0;
      wel       <= 1'b0;
      powerDown <= 1'b0;
    end else begin
      if (!lockoutDone) lockCnt <= lockCnt + 1'b1;
      if (strobe.setWel)      wel <= 1'b1;
      else if (strobe.clrWel) wel <= 1'b0;
      if (strobe.setPd)       powerDown <= 1'b1;
      else if (strobe.clrPd)  powerDown <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              status <= '0;
    else if (strobe.loadSr) status <= srNext;
  end

endmodule

// File: rtl/fpgCtrl.sv
module fpgCtrl
  import fpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       wpN,
  input  logic       opDone,
  input  logic       cmdWren,
  input  logic       cmdWrdi,
  input  logic       cmdProg,
  input  logic       cmdSectErase,
  input  logic       cmdBlkErase,
  input  logic       cmdChipErase,
  input  logic       cmdWrsr,
  input  logic       cmdPdown,
  input  logic       cmdRelPd,
  input  logic       wel,
  input  logic       powerDown,
  input  protBits_t  status,
  input  logic       lockoutDone,
  input  logic       protHit,
  output opKind_t    kind,
  output regStrobe_t strobe,
  output logic       acceptPulse,
  output logic       rejectPulse,
  output logic       opStart
);

  logic anyCmd, isWrite, srOpen;
  logic accNow, rejNow, startNow, hitClear;

  assign isWrite = cmdProg | cmdSectErase | cmdBlkErase | cmdChipErase;
  assign anyCmd  = isWrite | cmdWren | cmdWrdi | cmdWrsr | cmdPdown | cmdRelPd;
  assign srOpen  = !status.srp1 && (!status.srp0 || wpN);

  always_comb begin
    if (cmdChipErase)      kind = OP_CHIP;
    else if (cmdBlkErase)  kind = OP_BLK;
    else if (cmdSectErase) kind = OP_SECT;
    else                   kind = OP_PROG;
  end

  always_comb begin
    accNow   = 1'b0;
    rejNow   = 1'b0;
    startNow = 1'b0;
    hitClear = 1'b0;
    if (!pwrGood) begin
      accNow = 1'b0;
    end else if (powerDown) begin
      if (cmdRelPd)    accNow = 1'b1;
      else if (anyCmd) rejNow = 1'b1;
    end else if (cmdRelPd || cmdPdown || cmdWrdi) begin
      accNow = 1'b1;
    end else if (cmdWren) begin
      accNow = lockoutDone;
      rejNow = !lockoutDone;
    end else if (cmdWrsr) begin
      accNow   = lockoutDone && wel && srOpen;
      rejNow   = !accNow;
      startNow = accNow;
    end else if (isWrite) begin
      accNow   = lockoutDone && wel && !protHit;
      rejNow   = !accNow;
      startNow = accNow;
      hitClear = lockoutDone && wel && protHit;
    end
  end

  always_comb begin
    strobe.setWel = accNow && cmdWren && !powerDown;
    strobe.clrWel = (accNow && cmdWrdi && !powerDown) || hitClear || opDone;
    strobe.setPd  = accNow && cmdPdown && !powerDown;
    strobe.clrPd  = accNow && cmdRelPd;
    strobe.loadSr = accNow && cmdWrsr && !powerDown;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptPulse <= 1'b0;
      rejectPulse <= 1'b0;
      opStart     <= 1'b0;
    end else begin
      acceptPulse <= accNow;
      rejectPulse <= rejNow;
      opStart     <= startNow;
    end
  end

endmodule

// File: rtl/flashProtectGate.sv
module flashProtectGate
  import fpg_pkg::*;
#(
  parameter int ADDR_W         = 22,
  parameter int SECTOR_AW      = 12,
  parameter int BLOCK_AW       = 16,
  parameter int LOCKOUT_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              wpN,
  input  logic              opDone,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdProg,
  input  logic              cmdSectErase,
  input  logic              cmdBlkErase,
  input  logic              cmdChipErase,
  input  logic              cmdWrsr,
  input  logic              cmdPdown,
  input  logic              cmdRelPd,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [6:0]        srIn,
  output logic              acceptPulse,
  output logic              rejectPulse,
  output logic              opStart,
  output logic              wel,
  output logic              powerDown,
  output logic              writeLock,
  output logic [6:0]        srBits
);

  regStrobe_t strobe;
  protBits_t  status;
  opKind_t    kind;
  logic       lockoutDone;
  logic       protHit;

  fpgCtrl uCtrl (
    .clk, .rstN, .pwrGood, .wpN, .opDone,
    .cmdWren, .cmdWrdi, .cmdProg, .cmdSectErase, .cmdBlkErase,
    .cmdChipErase, .cmdWrsr, .cmdPdown, .cmdRelPd,
    .wel, .powerDown, .status, .lockoutDone, .protHit,
    .kind, .strobe, .acceptPulse, .rejectPulse, .opStart
  );

  fpgRegs #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) uRegs (
    .clk, .rstN, .pwrGood, .strobe,
    .srNext(protBits_t'(srIn)),
    .wel, .powerDown, .status, .lockoutDone
  );

  fpgRegion #(.ADDR_W(ADDR_W), .SECTOR_AW(SECTOR_AW), .BLOCK_AW(BLOCK_AW)) uRegion (
    .prot(status), .kind, .addr(targetAddr), .hit(protHit)
  );

  assign writeLock = !lockoutDone;
  assign srBits    = status;

endmodule

// File: rtl/fpgChecker.sv
module fpgChecker (
  input logic       clk,
  input logic       rstN,
  input logic       pwrGood,
  input logic       opDone,
  input logic       cmdWren,
  input logic       cmdWrdi,
  input logic       cmdProg,
  input logic       cmdWrsr,
  input logic       acceptPulse,
  input logic       rejectPulse,
  input logic       opStart,
  input logic       wel,
  input logic       powerDown,
  input logic       writeLock,
  input logic [6:0] srBits
);

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptPulse && rejectPulse)); // R10

  AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (!acceptPulse && !rejectPulse)); // R1

  AST_UNPOWERED_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (!wel && !powerDown)); // R1

  AST_LOCKOUT_WREN: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && writeLock && cmdWren) |=> rejectPulse); // R2

  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && !powerDown && cmdWrdi) |=> (acceptPulse && !wel)); // R3

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> $past(wel)); // R4

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !cmdWren) |=> !wel); // R5

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && powerDown && !opDone && (cmdWren || cmdProg)) |=>
      (rejectPulse && $stable(wel))); // R6

  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && srBits[6] && cmdWrsr) |=> (rejectPulse && $stable(srBits))); // R8

endmodule

bind flashProtectGate fpgChecker uChecker (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .opDone(opDone),
  .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdProg(cmdProg), .cmdWrsr(cmdWrsr),
  .acceptPulse(acceptPulse), .rejectPulse(rejectPulse), .opStart(opStart),
  .wel(wel), .powerDown(powerDown), .writeLock(writeLock), .srBits(srBits)
);

// File: tb/flashProtectGate_test.sv
`timescale 1ns/1ps
module flashProtectGate_test;

  localparam int AW   = 22;
  localparam int LOCK = 20;

  localparam int C_WREN = 0, C_WRDI = 1, C_PROG = 2, C_SECT = 3, C_BLK = 4,
                 C_CHIP = 5, C_WRSR = 6, C_PD = 7, C_REL = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0, pwrGood = 1'b0, wpN = 1'b1, opDone = 1'b0;
  logic cmdWren = 0, cmdWrdi = 0, cmdProg = 0, cmdSectErase = 0, cmdBlkErase = 0;
  logic cmdChipErase = 0, cmdWrsr = 0, cmdPdown = 0, cmdRelPd = 0;
  logic [AW-1:0] targetAddr = '0;
  logic [6:0] srIn = '0;
  logic acceptPulse, rejectPulse, opStart, wel, powerDown, writeLock;
  logic [6:0] srBits;

  always #4 clk = ~clk;

  flashProtectGate #(.ADDR_W(AW), .LOCKOUT_CYCLES(LOCK)) uut (
    .clk, .rstN, .pwrGood, .wpN, .opDone,
    .cmdWren, .cmdWrdi, .cmdProg, .cmdSectErase, .cmdBlkErase,
    .cmdChipErase, .cmdWrsr, .cmdPdown, .cmdRelPd,
    .targetAddr, .srIn,
    .acceptPulse, .rejectPulse, .opStart, .wel, .powerDown, .writeLock, .srBits
  );

  typedef struct {
    int    due;
    bit    acc, rej, op, wl, pd;
    logic [6:0] sr;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int checks = 0, errors = 0;
  logic [6:0] expSr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each expected item at the negedge of the cycle it is due
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      expItem_t it;
      logic [11:0] act, exp;
      it  = expQ.pop_front();
      act = {acceptPulse, rejectPulse, opStart, wel, powerDown, srBits};
      exp = {it.acc, it.rej, it.op, it.wl, it.pd, it.sr};
      chk(act === exp, it.tag, "acc/rej/op/wel/pd/sr", int'(act), int'(exp));
    end
  end

  task automatic issue(input int cmd, input logic [AW-1:0] a, input logic [6:0] d,
                       input bit eAcc, input bit eRej, input bit eWel, input bit ePd,
                       input string tag);
    expItem_t it;
    targetAddr = a;
    srIn = d;
    cmdWren = (cmd == C_WREN); cmdWrdi = (cmd == C_WRDI); cmdProg = (cmd == C_PROG);
    cmdSectErase = (cmd == C_SECT); cmdBlkErase = (cmd == C_BLK);
    cmdChipErase = (cmd == C_CHIP); cmdWrsr = (cmd == C_WRSR);
    cmdPdown = (cmd == C_PD); cmdRelPd = (cmd == C_REL);
    if (cmd == C_WRSR && eAcc) expSr = d;
    it.due = cyc + 1;
    it.acc = eAcc; it.rej = eRej; it.wl = eWel; it.pd = ePd; it.sr = expSr;
    it.op  = eAcc && (cmd >= C_PROG) && (cmd <= C_WRSR);
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    cmdWren = 0; cmdWrdi = 0; cmdProg = 0; cmdSectErase = 0; cmdBlkErase = 0;
    cmdChipErase = 0; cmdWrsr = 0; cmdPdown = 0; cmdRelPd = 0;
  endtask

  task automatic finishOp(input string tag);
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
    chk(wel === 1'b0, tag, "wel after opDone", int'(wel), 0);
  endtask

  task automatic enableWrite(input string tag);
    issue(C_WREN, '0, '0, 1, 0, 1, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({wel, powerDown, acceptPulse, rejectPulse} === 4'b0, "R1", "reset outputs",
        int'({wel, powerDown, acceptPulse, rejectPulse}), 0);
    chk(srBits === 7'd0, "R3", "reset srBits", int'(srBits), 0);
    chk(writeLock === 1'b1, "R2", "writeLock at reset", int'(writeLock), 1);
    rstN = 1'b1;
    @(negedge clk);
    // unpowered: no pulse at all
    issue(C_WREN, '0, '0, 0, 0, 0, 0, "R1 unpowered wren ignored");
    // lockout boundary
    pwrGood = 1'b1;
    repeat (LOCK - 1) @(negedge clk);
    chk(writeLock === 1'b1, "R2", "writeLock one cycle before end", int'(writeLock), 1);
    issue(C_WREN, '0, '0, 0, 1, 0, 0, "R2 wren in lockout");
    chk(writeLock === 1'b0, "R2", "writeLock released", int'(writeLock), 0);
    issue(C_PROG, 22'h000100, '0, 0, 1, 0, 0, "R4 prog without wel");
    enableWrite("R3 wren accepted");
    @(negedge clk);
    chk({acceptPulse, rejectPulse} === 2'b00, "R10", "pulse lasts one cycle",
        int'({acceptPulse, rejectPulse}), 0);
    issue(C_WRDI, '0, '0, 1, 0, 0, 0, "R3 wrdi clears");
    enableWrite("R3 wren");
    issue(C_PROG, 22'h000100, '0, 1, 0, 1, 0, "R10 prog accepted");
    finishOp("R5");
    // power-down
    issue(C_PD, '0, '0, 1, 0, 0, 1, "R6 power-down");
    issue(C_WREN, '0, '0, 0, 1, 0, 1, "R6 wren ignored in pd");
    issue(C_WRDI, '0, '0, 0, 1, 0, 1, "R6 wrdi ignored in pd");
    issue(C_REL, '0, '0, 1, 0, 0, 0, "R6 release");
    // top 64 KiB protected
    enableWrite("R7 wren");
    issue(C_WRSR, '0, 7'b00_00_001, 1, 0, 1, 0, "R7 status write");
    finishOp("R5");
    enableWrite("R9 wren");
    issue(C_PROG, 22'h3F0000, '0, 0, 1, 0, 0, "R9 prog in top region");
    enableWrite("R9 wren");
    issue(C_PROG, 22'h3EFFFF, '0, 1, 0, 1, 0, "R9 prog below region");
    finishOp("R5");
    enableWrite("R9 wren");
    issue(C_SECT, 22'h3EF123, '0, 1, 0, 1, 0, "R9 sector below region");
    finishOp("R5");
    enableWrite("R11 wren");
    issue(C_CHIP, '0, '0, 0, 1, 0, 0, "R11 chip erase protected");
    // bottom 8 KiB, sector granular
    enableWrite("R7 wren");
    issue(C_WRSR, '0, 7'b00_11_010, 1, 0, 1, 0, "R7 status write bottom");
    finishOp("R5");
    enableWrite("R9 wren");
    issue(C_PROG, 22'h001FFF, '0, 0, 1, 0, 0, "R9 prog in bottom region");
    enableWrite("R9 wren");
    issue(C_PROG, 22'h002000, '0, 1, 0, 1, 0, "R9 prog above region");
    finishOp("R5");
    enableWrite("R9 wren");
    issue(C_BLK, 22'h008000, '0, 0, 1, 0, 0, "R9 block overlapping region");
    enableWrite("R9 wren");
    issue(C_BLK, 22'h010000, '0, 1, 0, 1, 0, "R9 block clear of region");
    finishOp("R5");
    enableWrite("R11 wren");
    issue(C_WRSR, '0, 7'b00_00_000, 1, 0, 1, 0, "R7 clear protection");
    finishOp("R5");
    enableWrite("R11 wren");
    issue(C_CHIP, '0, '0, 1, 0, 1, 0, "R11 chip erase unprotected");
    finishOp("R5");
    // status-register protect
    enableWrite("R8 wren");
    issue(C_WRSR, '0, 7'b01_00_000, 1, 0, 1, 0, "R8 set srp0");
    finishOp("R5");
    wpN = 1'b0;
    enableWrite("R8 wren");
    issue(C_WRSR, '0, 7'b00_00_000, 0, 1, 1, 0, "R8 wrsr blocked by pin");
    wpN = 1'b1;
    issue(C_WRSR, '0, 7'b10_00_000, 1, 0, 1, 0, "R8 wrsr with pin high");
    finishOp("R5");
    enableWrite("R8 wren");
    issue(C_WRSR, '0, 7'b00_00_000, 0, 1, 1, 0, "R8 srp1 locks");
    // power loss
    pwrGood = 1'b0;
    @(negedge clk);
    chk({wel, powerDown, writeLock} === 3'b001, "R1", "power loss state",
        int'({wel, powerDown, writeLock}), 1);
    chk(srBits === 7'b10_00_000, "R1", "protection kept", int'(srBits), 'h40);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R10", "all expected results seen", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule